// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block merges five status conditions into one registered interrupt line. A host loads an 8-bit mask, and each mask bit sits at the same position as the status bit it enables. A 1 lets that status bit reach the interrupt, and a 0 hides it. The interrupt register samples the OR of every status bit ANDed with its mask bit.

The five sources follow two clearing styles. Receiver-inhibited and transmitter-available are level sources that follow live condition inputs. A masked level source comes back on the interrupt as soon as it is unmasked, provided its condition is still true. The other three are sticky flags set by one-cycle event pulses, and each has its own way to clear:
- Reconfiguration timeout clears on the clear-flags command.
- Excessive NAK clears only on the power-on clear-flags command.
- New next ID clears when the next-ID register is read.

A hardware reset clears everything. A soft reset clears only the mask.

Top module: `status_irq_unit`

## Requirements
- R1: While `rstN` is low and right after it rises, `irqOut` is 0 and `statusOut` is 0x00 apart from the live bits. The mask holds 0x00, so live conditions raise no interrupt until the mask is written.
- R2: A `softReset` pulse clears the mask to 0x00 and wins over a mask write in the same cycle. It leaves the sticky flags unchanged.
- R3: `irqOut` is registered. On each clock edge it loads the OR over all bits of (`statusOut` AND mask). A mask write or a sticky set event therefore reaches `irqOut` on the second edge, and a live input change reaches it on the first edge.
- R4: `statusOut[1]` (receiver inhibited) equals `rxInhibitLive` and `statusOut[0]` (transmitter available) equals `txAvailLive`. Clearing the mask bit hides the interrupt, and setting it again brings the interrupt back while the condition holds.
- R5: `statusOut[2]` (reconfiguration timeout) is set by `reconEvt` and cleared only by `clrFlagsCmd`.
- R6: `statusOut[3]` (excessive NAK) is set by `exNakEvt` and cleared only by `porClrCmd`. `clrFlagsCmd` does not touch it.
- R7: `statusOut[4]` (new next ID) is set by `newIdEvt` and cleared only by `nextIdRd`.
- R8: When a set event and its clear arrive in the same cycle, the flag ends up set.
- R9: Mask bits 7..5 have no source and do not affect `irqOut`. `statusOut[7:5]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| softReset | input | 1 | Soft reset strobe; clears the mask |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 8 | Mask value to write |
| rxInhibitLive | input | 1 | Live receiver-inhibited condition |
| txAvailLive | input | 1 | Live transmitter-available condition |
| reconEvt | input | 1 | Reconfiguration-timeout set pulse |
| exNakEvt | input | 1 | Excessive-NAK set pulse |
| newIdEvt | input | 1 | New-next-ID set pulse |
| clrFlagsCmd | input | 1 | Clear-flags command strobe |
| porClrCmd | input | 1 | Power-on clear-flags command strobe |
| nextIdRd | input | 1 | Read strobe of the next-ID register |
| statusOut | output | 8 | Status vector: bit0 tx avail, bit1 rx inhibit, bit2 recon, bit3 excessive NAK, bit4 new ID, bits7..5 zero |
| irqOut | output | 1 | Registered interrupt |

## Verification
A mask write or a sticky set event is due on `irqOut` two clock edges after the input is driven. A live condition change is due on the first edge. Sticky status bits show their new value after one edge.

The bench drives inputs on falling edges and samples on later falling edges. For each result it waits the exact number of edges above before sampling. The event tests also sample `irqOut` one edge early to confirm it has not yet changed.

// File: rtl/status_irq_pkg.sv
package status_irq_pkg;
  localparam int MASK_W  = 8;
  localparam int STICKY_N = 3;

  // Status bit positions (mask uses the same positions)
  localparam int POS_TXAV  = 0;
  localparam int POS_RXINH = 1;
  localparam int POS_RECON = 2;
  localparam int POS_EXNAK = 3;
  localparam int POS_NEWID = 4;

  // Sticky flag index 0..2 -> status position
  function automatic int stickyPos(input int idx);
    case (idx)
      0:       return POS_RECON;
      1:       return POS_EXNAK;
      default: return POS_NEWID;
    endcase
  endfunction

  typedef struct packed {
    logic                maskLoad;
    logic                maskClear;
    logic [STICKY_N-1:0] stickySet;
    logic [STICKY_N-1:0] stickyClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/status_irq_ctrl.sv
module status_irq_ctrl
  import status_irq_pkg::*;
(
  input  logic         softReset,
  input  logic         maskWrEn,
  input  logic         reconEvt,
  input  logic         exNakEvt,
  input  logic         newIdEvt,
  input  logic         clrFlagsCmd,
  input  logic         porClrCmd,
  input  logic         nextIdRd,
  output ctrlStrobes_t strb
);
  always_comb begin
    strb.maskClear = softReset;
    strb.maskLoad  = maskWrEn & ~softReset;
    // index order: 0 recon, 1 excessive NAK, 2 new ID
    strb.stickySet = {newIdEvt, exNakEvt, reconEvt};
    strb.stickyClr = {nextIdRd, porClrCmd, clrFlagsCmd};
  end
endmodule

// File: rtl/status_irq_path.sv
module status_irq_path
  import status_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [MASK_W-1:0] maskWrData,
  input  logic              rxInhibitLive,
  input  logic              txAvailLive,
  output logic [MASK_W-1:0] maskQ,
  output logic [MASK_W-1:0] statusVec,
  output logic              irqQ
);
  logic [STICKY_N-1:0] stickyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskQ <= '0;
    else if (strb.maskClear) maskQ <= '0;
    else if (strb.maskLoad)  maskQ <= maskWrData;
  end

  for (genvar i = 0; i < STICKY_N; i++) begin : gSticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  stickyQ[i] <= 1'b0;
      else if (strb.stickySet[i]) stickyQ[i] <= 1'b1;
      else if (strb.stickyClr[i]) stickyQ[i] <= 1'b0;
    end
  end

  always_comb begin
    statusVec = '0;
    statusVec[POS_TXAV]  = txAvailLive;
    statusVec[POS_RXINH] = rxInhibitLive;
    for (int i = 0; i < STICKY_N; i++) statusVec[stickyPos(i)] = stickyQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusVec & maskQ);
  end
endmodule

// File: rtl/status_irq_unit.sv
module status_irq_unit
  import status_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  logic              maskWrEn,
  input  logic [MASK_W-1:0] maskWrData,
  input  logic              rxInhibitLive,
  input  logic              txAvailLive,
  input  logic              reconEvt,
  input  logic              exNakEvt,
  input  logic              newIdEvt,
  input  logic              clrFlagsCmd,
  input  logic              porClrCmd,
  input  logic              nextIdRd,
  output logic [MASK_W-1:0] statusOut,
  output logic              irqOut
);
  ctrlStrobes_t      strb;
  logic [MASK_W-1:0] maskQ;

  status_irq_ctrl uCtrl (
    .softReset(softReset), .maskWrEn(maskWrEn),
    .reconEvt(reconEvt), .exNakEvt(exNakEvt), .newIdEvt(newIdEvt),
    .clrFlagsCmd(clrFlagsCmd), .porClrCmd(porClrCmd), .nextIdRd(nextIdRd),
    .strb(strb)
  );

  status_irq_path uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .maskWrData(maskWrData),
    .rxInhibitLive(rxInhibitLive), .txAvailLive(txAvailLive),
    .maskQ(maskQ), .statusVec(statusOut), .irqQ(irqOut)
  );
endmodule

// File: rtl/status_irq_unit_chk.sv
module status_irq_unit_chk
  import status_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              softReset,
  input logic              reconEvt,
  input logic              exNakEvt,
  input logic              newIdEvt,
  input logic              clrFlagsCmd,
  input logic              porClrCmd,
  input logic              nextIdRd,
  input logic [MASK_W-1:0] maskQ,
  input logic [MASK_W-1:0] statusOut,
  input logic              irqOut
);
  // R3
  irq_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|(statusOut & maskQ)));
  // R2
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> maskQ == '0);
  // R5
  recon_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[POS_RECON] && !clrFlagsCmd |=> statusOut[POS_RECON]);
  // R6
  exnak_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[POS_EXNAK] && !porClrCmd |=> statusOut[POS_EXNAK]);
  // R7
  newid_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    nextIdRd && !newIdEvt |=> !statusOut[POS_NEWID]);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    reconEvt || exNakEvt || newIdEvt |=>
      (!$past(reconEvt) || statusOut[POS_RECON]) &&
      (!$past(exNakEvt) || statusOut[POS_EXNAK]) &&
      (!$past(newIdEvt) || statusOut[POS_NEWID]));
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[7:5] == 3'b000);
endmodule

bind status_irq_unit status_irq_unit_chk uChk (
  .clk(clk), .rstN(rstN), .softReset(softReset),
  .reconEvt(reconEvt), .exNakEvt(exNakEvt), .newIdEvt(newIdEvt),
  .clrFlagsCmd(clrFlagsCmd), .porClrCmd(porClrCmd), .nextIdRd(nextIdRd),
  .maskQ(maskQ), .statusOut(statusOut), .irqOut(irqOut)
);

// File: tb/status_irq_unit_test.sv
module status_irq_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softReset = 0, maskWrEn = 0;
  logic [7:0] maskWrData = '0;
  logic       rxInhibitLive = 0, txAvailLive = 0;
  logic       reconEvt = 0, exNakEvt = 0, newIdEvt = 0;
  logic       clrFlagsCmd = 0, porClrCmd = 0, nextIdRd = 0;
  logic [7:0] statusOut;
  logic       irqOut;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  status_irq_unit uut (.*);

  // {mask[7:0], rx, tx, expIrq}
  localparam logic [10:0] VEC [8] = '{
    {8'h00, 1'b1, 1'b1, 1'b0},
    {8'h01, 1'b0, 1'b1, 1'b1},
    {8'h02, 1'b1, 1'b0, 1'b1},
    {8'h02, 1'b0, 1'b1, 1'b0},
    {8'hE0, 1'b1, 1'b1, 1'b0},
    {8'h1C, 1'b1, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b0, 1'b0},
    {8'h03, 1'b0, 1'b1, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeMask(input logic [7:0] m);
    maskWrData = m; maskWrEn = 1; step(1); maskWrEn = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(1); s = 0;
  endtask

  initial begin
    step(2);
    // R1: reset state
    check("R1 irq in reset", {7'd0, irqOut}, 8'h00);
    check("R1 status in reset", statusOut, 8'h00);
    rstN = 1; step(1);
    rxInhibitLive = 1; txAvailLive = 1; step(2);
    check("R1 mask zero after reset", {7'd0, irqOut}, 8'h00);
    check("R1 sticky zero", statusOut[4:2], 3'b000);

    // Table: live sources against mask patterns (R3 R4 R9)
    foreach (VEC[i]) begin
      rxInhibitLive = VEC[i][2]; txAvailLive = VEC[i][1];
      writeMask(VEC[i][10:3]);
      step(1);
      check($sformatf("R4 live status vec %0d", i), {6'd0, statusOut[1:0]}, {6'd0, VEC[i][2:1]});
      check($sformatf("R3 irq vec %0d", i), {7'd0, irqOut}, {7'd0, VEC[i][0]});
      check($sformatf("R9 upper status vec %0d", i), {5'd0, statusOut[7:5]}, 8'h00);
    end
    rxInhibitLive = 0; txAvailLive = 0; writeMask(8'h00); step(1);

    // R4: unmask re-asserts while condition holds
    rxInhibitLive = 1; writeMask(8'h02); step(1);
    check("R4 rx irq", {7'd0, irqOut}, 8'h01);
    writeMask(8'h00); step(1);
    check("R4 rx masked", {7'd0, irqOut}, 8'h00);
    writeMask(8'h02); step(1);
    check("R4 rx reappears", {7'd0, irqOut}, 8'h01);
    rxInhibitLive = 0; step(1);
    check("R3 live drop next edge", {7'd0, irqOut}, 8'h00);

    // R5 + R3 timing
    writeMask(8'h04); step(1);
    pulse(reconEvt);
    check("R5 recon set", {7'd0, statusOut[2]}, 8'h01);
    check("R3 irq not yet", {7'd0, irqOut}, 8'h00);
    step(1);
    check("R3 irq second edge", {7'd0, irqOut}, 8'h01);
    pulse(porClrCmd); pulse(nextIdRd);
    check("R5 recon kept by other clears", {7'd0, statusOut[2]}, 8'h01);
    pulse(clrFlagsCmd);
    check("R5 recon cleared", {7'd0, statusOut[2]}, 8'h00);
    step(1);
    check("R5 irq dropped", {7'd0, irqOut}, 8'h00);

    // R6
    writeMask(8'h08);
    pulse(exNakEvt); step(1);
    check("R6 exnak irq", {7'd0, irqOut}, 8'h01);
    pulse(clrFlagsCmd); pulse(nextIdRd); step(1);
    check("R6 exnak kept", {7'd0, statusOut[3]}, 8'h01);
    check("R6 exnak irq kept", {7'd0, irqOut}, 8'h01);
    pulse(porClrCmd);
    check("R6 exnak cleared", {7'd0, statusOut[3]}, 8'h00);

    // R7
    writeMask(8'h10);
    pulse(newIdEvt); step(1);
    check("R7 newid irq", {7'd0, irqOut}, 8'h01);
    pulse(clrFlagsCmd); pulse(porClrCmd);
    check("R7 newid kept", {7'd0, statusOut[4]}, 8'h01);
    pulse(nextIdRd);
    check("R7 newid cleared", {7'd0, statusOut[4]}, 8'h00);
    step(1);
    check("R7 irq dropped", {7'd0, irqOut}, 8'h00);

    // R8: set and clear together
    reconEvt = 1; clrFlagsCmd = 1; exNakEvt = 1; porClrCmd = 1;
    newIdEvt = 1; nextIdRd = 1; step(1);
    reconEvt = 0; clrFlagsCmd = 0; exNakEvt = 0; porClrCmd = 0;
    newIdEvt = 0; nextIdRd = 0;
    check("R8 set wins", {3'd0, statusOut[4:0]}, 8'h1C);

    // R9: only unused mask bits set, all sources active
    txAvailLive = 1; rxInhibitLive = 1;
    writeMask(8'hE0); step(1);
    check("R9 unused mask bits", {7'd0, irqOut}, 8'h00);

    // R2: soft reset clears mask, wins over write, keeps flags
    writeMask(8'h1F); step(1);
    check("R2 irq before soft reset", {7'd0, irqOut}, 8'h01);
    maskWrData = 8'h1F; maskWrEn = 1; softReset = 1; step(1);
    maskWrEn = 0; softReset = 0; step(1);
    check("R2 mask cleared", {7'd0, irqOut}, 8'h00);
    check("R2 flags kept", {3'd0, statusOut[4:0]}, 8'h1F);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); end
    join_any
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule